// File: doc/BRIEF.md
# Instruction Decode and Trap Control

This block turns one 32-bit instruction word into the control signals for a single-cycle datapath. It handles a small load/store RISC subset: word load, word store, the register-to-register operations add, subtract, and, or, nor and signed set-less-than, an equality branch, and an absolute jump. It also produces the sign-extended immediate, the destination register index and the jump target. The ALU and the register file sit outside the block.

The same decode checks every instruction for two faults. An opcode or function code outside the subset is an undefined instruction. A signed add or subtract that overflows is an arithmetic fault; the ALU reports the overflow on a flag input. On a fault, the block blocks every architectural side effect of that instruction and asserts a redirect so that fetch goes to a fixed handler address. On the next clock edge it records the faulting PC and a cause code in two trap registers. Those registers keep their values until the next fault.

Top module: `dtc_top`

## Requirements
- R1: `imm_ext_o` equals bits [15:0] of the instruction with bit 15 copied into bits [31:16], for every instruction.
- R2: Opcode 000000 with function code 100000/100010/100100/100101/100111 gives `alu_op_o` 0/1/2/3/4. It also asserts `reg_write_o` and `reg_dst_rd_o`, and `wr_addr_o` is bits [15:11].
- R3: Opcode 100011 (load) asserts `mem_read_o`, `mem_to_reg_o`, `alu_src_imm_o` and `reg_write_o`, with `alu_op_o`=0 and `wr_addr_o` equal to bits [20:16]. Opcode 101011 (store) asserts `mem_write_o` and `alu_src_imm_o`, and does not assert `reg_write_o`.
- R4: Opcode 000100 asserts `branch_o` with `alu_op_o`=1 and no writes. Opcode 000010 asserts `jump_o`, and `jump_target_o` is {bits [31:28] of PC+4, instruction bits [25:0], 00}.
- R5: Function code 101010 under opcode 000000 selects the signed compare, `alu_op_o`=5, and writes bits [15:11].
- R6: `reg_write_o` is never asserted when `wr_addr_o` is 0.
- R7: An opcode outside the subset, or an unknown function code under opcode 000000, asserts `exc_o` and `exc_redirect_o` in the same cycle, with `handler_pc_o`=0x80000180. At the next clock edge `epc_o` takes `pc_i` and `cause_o` takes 0.
- R8: `alu_ovf_i` raises an exception (cause 1, EPC captured) only during the add and subtract function codes. For every other instruction it is ignored.
- R9: During a faulting instruction, `reg_write_o`, `mem_write_o`, `mem_read_o`, `branch_o` and `jump_o` are all low.
- R10: Reset clears `epc_o` and `cause_o`. Both hold their values across every cycle that has no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | 32 | Address of that instruction |
| alu_ovf_i | input | 1 | Signed overflow flag from the ALU |
| reg_write_o | output | 1 | Register file write enable |
| wr_addr_o | output | 5 | Destination register index |
| reg_dst_rd_o | output | 1 | Destination taken from bits [15:11] |
| mem_read_o | output | 1 | Data memory read |
| mem_write_o | output | 1 | Data memory write |
| mem_to_reg_o | output | 1 | Write-back from memory instead of ALU |
| alu_src_imm_o | output | 1 | ALU second operand is the immediate |
| alu_op_o | output | 3 | ALU operation code |
| branch_o | output | 1 | Equality branch instruction |
| jump_o | output | 1 | Jump instruction |
| imm_ext_o | output | 32 | Sign-extended immediate |
| jump_target_o | output | 32 | Absolute jump destination |
| exc_o | output | 1 | Current instruction faults |
| exc_redirect_o | output | 1 | Fetch must go to handler address |
| handler_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | PC of the last faulting instruction |
| cause_o | output | 5 | Code of the last fault |

## Verification
The hardest case to reach from the ports is the arithmetic fault. It only occurs when the overflow flag, which comes from outside, arrives together with an add or subtract function code. The same flag must have no effect on loads, logical operations and compares. The bench drives the flag high during each of those instructions and checks that no trap and no register change follow. It then checks that the trap registers keep the values from an earlier fault while several clean instructions pass.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FN_W     = 6;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned TGT_W    = 26;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BREQ = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOR = 3'd4,
    ALU_SLT = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst_rd;
    logic    mem_read;
    logic    mem_write;
    logic    mem_to_reg;
    logic    alu_src_imm;
    logic    branch;
    logic    jump;
    logic    undefined;
    logic    ovf_check;
    alu_op_e alu_op;
  } ctrl_t;

  localparam int unsigned CAUSE_UNDEF = 0;
  localparam int unsigned CAUSE_OVF   = 1;

endpackage

// File: rtl/dtc_decode.sv
module dtc_decode
  import dtc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (opcode_i)
      OPC_REG: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.reg_dst_rd = 1'b1;
        unique case (funct_i)
          FN_ADD: begin ctrl_o.alu_op = ALU_ADD; ctrl_o.ovf_check = 1'b1; end
          FN_SUB: begin ctrl_o.alu_op = ALU_SUB; ctrl_o.ovf_check = 1'b1; end
          FN_AND: ctrl_o.alu_op = ALU_AND;
          FN_OR:  ctrl_o.alu_op = ALU_OR;
          FN_NOR: ctrl_o.alu_op = ALU_NOR;
          FN_SLT: ctrl_o.alu_op = ALU_SLT;
          default: begin
            ctrl_o.reg_write  = 1'b0;
            ctrl_o.reg_dst_rd = 1'b0;
            ctrl_o.undefined  = 1'b1;
          end
        endcase
      end
      OPC_LOAD: begin
        ctrl_o.reg_write   = 1'b1;
        ctrl_o.mem_read    = 1'b1;
        ctrl_o.mem_to_reg  = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
      end
      OPC_STOR: begin
        ctrl_o.mem_write   = 1'b1;
        ctrl_o.alu_src_imm = 1'b1;
      end
      OPC_BREQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OPC_JMP: ctrl_o.jump = 1'b1;
      default: ctrl_o.undefined = 1'b1;
    endcase
  end

endmodule

// File: rtl/dtc_sext.sv
module dtc_sext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);

  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W == 0) begin : g_same
      assign val_o = val_i;
    end else begin : g_pad
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end
  endgenerate

endmodule

// File: rtl/dtc_trap_regs.sv
module dtc_trap_regs #(
  parameter int unsigned AW      = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_en_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [CAUSE_W-1:0] code_i,
  output logic [AW-1:0]      epc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [AW-1:0]      epc_q, epc_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  always_comb begin
    epc_d   = epc_q;
    cause_d = cause_q;
    if (trap_en_i) begin
      epc_d   = pc_i;
      cause_d = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (trap_en_i) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;

  assert_epc_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en_i |=> (epc_o == $past(pc_i)) && (cause_o == $past(code_i)));

  assert_trap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en_i |=> $stable(epc_o) && $stable(cause_o));

endmodule

// File: rtl/dtc_top.sv
module dtc_top
  import dtc_pkg::*;
#(
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180,
  parameter int unsigned CAUSE_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        instr_i,
  input  logic [31:0]        pc_i,
  input  logic               alu_ovf_i,
  output logic               reg_write_o,
  output logic [4:0]         wr_addr_o,
  output logic               reg_dst_rd_o,
  output logic               mem_read_o,
  output logic               mem_write_o,
  output logic               mem_to_reg_o,
  output logic               alu_src_imm_o,
  output logic [2:0]         alu_op_o,
  output logic               branch_o,
  output logic               jump_o,
  output logic [31:0]        imm_ext_o,
  output logic [31:0]        jump_target_o,
  output logic               exc_o,
  output logic               exc_redirect_o,
  output logic [31:0]        handler_pc_o,
  output logic [31:0]        epc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int unsigned REGION_W = XLEN - TGT_W - 2;

  logic [OPC_W-1:0]    opcode;
  logic [FN_W-1:0]     funct;
  logic [RIDX_W-1:0]   rt_idx, rd_idx;
  ctrl_t               ctrl;
  logic                exc_undef, exc_ovf, exc;
  logic [CAUSE_W-1:0]  code;
  logic [REGION_W-1:0] pc_region;

  assign opcode = instr_i[31:26];
  assign funct  = instr_i[5:0];
  assign rt_idx = instr_i[20:16];
  assign rd_idx = instr_i[15:11];

  dtc_decode u_decode (
    .opcode_i (opcode),
    .funct_i  (funct),
    .ctrl_o   (ctrl)
  );

  dtc_sext #(.IN_W(IMM_W), .OUT_W(XLEN)) u_sext (
    .val_i (instr_i[IMM_W-1:0]),
    .val_o (imm_ext_o)
  );

  assign exc_undef = ctrl.undefined;
  assign exc_ovf   = ctrl.ovf_check & alu_ovf_i;
  assign exc       = exc_undef | exc_ovf;
  assign code      = exc_undef ? CAUSE_W'(CAUSE_UNDEF) : CAUSE_W'(CAUSE_OVF);

  dtc_trap_regs #(.AW(XLEN), .CAUSE_W(CAUSE_W)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_en_i (exc),
    .pc_i      (pc_i),
    .code_i    (code),
    .epc_o     (epc_o),
    .cause_o   (cause_o)
  );

  // Region bits of PC+4: PC+4 carries into bit 28 only when bits [27:2] are all ones.
  assign pc_region = pc_i[XLEN-1:XLEN-REGION_W] + REGION_W'(&pc_i[XLEN-REGION_W-1:2]);

  assign wr_addr_o      = ctrl.reg_dst_rd ? rd_idx : rt_idx;
  assign reg_dst_rd_o   = ctrl.reg_dst_rd;
  assign reg_write_o    = ctrl.reg_write & ~exc & (wr_addr_o != '0);
  assign mem_read_o     = ctrl.mem_read & ~exc;
  assign mem_write_o    = ctrl.mem_write & ~exc;
  assign mem_to_reg_o   = ctrl.mem_to_reg;
  assign alu_src_imm_o  = ctrl.alu_src_imm;
  assign alu_op_o       = ctrl.alu_op;
  assign branch_o       = ctrl.branch & ~exc;
  assign jump_o         = ctrl.jump & ~exc;
  assign jump_target_o  = {pc_region, instr_i[TGT_W-1:0], 2'b00};
  assign exc_o          = exc;
  assign exc_redirect_o = exc;
  assign handler_pc_o   = HANDLER_PC;

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_write_o |-> (wr_addr_o != 5'd0));

  assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !(reg_write_o || mem_write_o || mem_read_o || branch_o || jump_o));

  assert_ovf_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ovf_i && (opcode != OPC_REG)) |-> (exc_o == (opcode != OPC_LOAD && opcode != OPC_STOR &&
                                                    opcode != OPC_BREQ && opcode != OPC_JMP)));

  assert_single_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_write_o, mem_write_o, branch_o, jump_o}));

endmodule

// File: tb/dtc_top_tb.sv
module dtc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr, pc;
  logic        ovf;
  logic        reg_write, reg_dst_rd, mem_read, mem_write, mem_to_reg, alu_src_imm;
  logic        branch, jump, exc, exc_redirect;
  logic [4:0]  wr_addr, cause;
  logic [2:0]  alu_op;
  logic [31:0] imm_ext, jump_target, handler_pc, epc;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dtc_top u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_i(pc), .alu_ovf_i(ovf),
    .reg_write_o(reg_write), .wr_addr_o(wr_addr), .reg_dst_rd_o(reg_dst_rd),
    .mem_read_o(mem_read), .mem_write_o(mem_write), .mem_to_reg_o(mem_to_reg),
    .alu_src_imm_o(alu_src_imm), .alu_op_o(alu_op), .branch_o(branch), .jump_o(jump),
    .imm_ext_o(imm_ext), .jump_target_o(jump_target), .exc_o(exc),
    .exc_redirect_o(exc_redirect), .handler_pc_o(handler_pc), .epc_o(epc), .cause_o(cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rins(input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, 5'd3, rt, rd, 5'd0, fn};
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] p, input logic o);
    @(negedge clk);
    instr = i; pc = p; ovf = o;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R10 epc reset", epc, 32'h0);
    check("R10 cause reset", {27'd0, cause}, 32'h0);
  endtask

  task automatic t_rtype;
    logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2a};
    for (int k = 0; k < 6; k++) begin
      apply(rins(5'd4, 5'd9, fns[k]), 32'h100, 1'b0);
      check(k == 5 ? "R5 alu op" : "R2 alu op", {29'd0, alu_op}, k);
      check("R2 reg_write", {31'd0, reg_write}, 1);
      check("R2 reg_dst", {31'd0, reg_dst_rd}, 1);
      check("R2 wr_addr", {27'd0, wr_addr}, 9);
      check("R2 no exc", {31'd0, exc}, 0);
    end
  endtask

  task automatic t_load_store;
    apply({6'b100011, 5'd2, 5'd7, 16'hFFF0}, 32'h200, 1'b1);
    check("R1 imm negative", imm_ext, 32'hFFFF_FFF0);
    check("R3 load ctrl", {28'd0, mem_read, mem_to_reg, alu_src_imm, reg_write}, 32'hF);
    check("R3 load addr", {27'd0, wr_addr}, 7);
    check("R3 load alu add", {29'd0, alu_op}, 0);
    check("R8 ovf ignored on load", {31'd0, exc}, 0);
    apply({6'b101011, 5'd2, 5'd7, 16'h7FF4}, 32'h204, 1'b0);
    check("R1 imm positive", imm_ext, 32'h0000_7FF4);
    check("R3 store ctrl", {28'd0, mem_write, alu_src_imm, reg_write, mem_read}, 32'hC);
  endtask

  task automatic t_branch_jump;
    apply({6'b000100, 5'd8, 5'd9, 16'h8000}, 32'h300, 1'b0);
    check("R4 branch", {29'd0, branch, reg_write, mem_write}, 32'h4);
    check("R4 branch alu sub", {29'd0, alu_op}, 1);
    check("R1 branch disp", imm_ext, 32'hFFFF_8000);
    apply({6'b000010, 26'h3A5_5A5A}, 32'h1FFF_FFFC, 1'b0);
    check("R4 jump", {31'd0, jump}, 1);
    check("R4 jump target carry", jump_target, {4'h2, 26'h3A5_5A5A, 2'b00});
    apply({6'b000010, 26'h000_0010}, 32'h4000_0100, 1'b0);
    check("R4 jump target", jump_target, 32'h4000_0040);
  endtask

  task automatic t_zero_reg;
    apply(rins(5'd4, 5'd0, 6'h20), 32'h400, 1'b0);
    check("R6 rd zero no write", {31'd0, reg_write}, 0);
    apply({6'b100011, 5'd2, 5'd0, 16'h0004}, 32'h404, 1'b0);
    check("R6 load rt zero no write", {31'd0, reg_write}, 0);
  endtask

  task automatic t_undef_opcode;
    apply({6'b001000, 5'd1, 5'd2, 16'h0001}, 32'h0000_0508, 1'b0);
    check("R7 exc", {30'd0, exc, exc_redirect}, 3);
    check("R7 handler", handler_pc, 32'h8000_0180);
    check("R9 quiet", {27'd0, reg_write, mem_write, mem_read, branch, jump}, 0);
    tick;
    check("R7 epc", epc, 32'h0000_0508);
    check("R7 cause undef", {27'd0, cause}, 0);
  endtask

  task automatic t_overflow;
    apply(rins(5'd4, 5'd9, 6'h22), 32'h0000_0610, 1'b1);
    check("R8 sub ovf exc", {31'd0, exc}, 1);
    check("R9 ovf no write", {31'd0, reg_write}, 0);
    tick;
    check("R8 epc", epc, 32'h0000_0610);
    check("R8 cause ovf", {27'd0, cause}, 1);
    apply(rins(5'd4, 5'd9, 6'h24), 32'h0000_0614, 1'b1);
    check("R8 and ovf ignored", {30'd0, exc, reg_write}, 1);
    apply(rins(5'd4, 5'd9, 6'h2a), 32'h0000_0618, 1'b1);
    check("R8 slt ovf ignored", {30'd0, exc, reg_write}, 1);
    tick;
    check("R8 epc unchanged", epc, 32'h0000_0610);
  endtask

  task automatic t_undef_funct;
    apply(rins(5'd4, 5'd9, 6'h01), 32'h0000_0700, 1'b1);
    check("R7 bad funct exc", {31'd0, exc}, 1);
    check("R9 bad funct quiet", {31'd0, reg_write}, 0);
    tick;
    check("R7 bad funct cause", {27'd0, cause}, 0);
    check("R7 bad funct epc", epc, 32'h0000_0700);
  endtask

  task automatic t_hold;
    apply(rins(5'd4, 5'd9, 6'h20), 32'h0000_0800, 1'b0);
    apply({6'b101011, 5'd2, 5'd7, 16'h0008}, 32'h0000_0804, 1'b1);
    apply({6'b000100, 5'd8, 5'd9, 16'h0002}, 32'h0000_0808, 1'b1);
    tick;
    check("R10 epc held", epc, 32'h0000_0700);
    check("R10 cause held", {27'd0, cause}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    instr = rins(5'd1, 5'd1, 6'h25);
    pc = 32'h0;
    ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_rtype;
    t_load_store;
    t_branch_jump;
    t_zero_reg;
    t_undef_opcode;
    t_overflow;
    t_undef_funct;
    t_hold;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule